// File: doc/BRIEF.md
# Selectable-Source Counter Timebase with Mode Register

This block holds a 16-bit free-running counter. A one-byte mode register picks what steps the counter: a divided system clock, the system clock itself, a timer-overflow pulse, falling edges on an external count pin, or a divided external oscillator. The counter wraps from its top value to zero, and the wrap raises a sticky overflow flag. An interrupt request follows that flag when the interrupt-enable field allows it. The counter can also be frozen while the processor reports idle.

The same register holds a watchdog-enable bit, which is set out of reset, and a lock bit. While the watchdog is enabled, the register is write-protected. The only change a write can make then is to clear the enable, and the lock blocks even that until the next reset. Software writes the register through a plain byte write strobe and reads it back on a combinational read port. The flag has its own clear input.

Top module: `ctr_timebase`

## Requirements
- R1: On reset the mode register reads 0x40: the watchdog is enabled and source code 000 is selected. The counter is 0 and the overflow flag is 0.
- R2: Field positions in the mode register: bit7 is idle-freeze, bit6 is watchdog enable, bit5 is lock, bit4 always reads 0, bits3..1 are the source code, and bit0 is the overflow interrupt enable.
- R3: Source 000 adds one count every 12 system clocks. Source 001 adds one every 4 system clocks. Source 100 adds one every system clock.
- R4: Source 010 adds one count for each system-clock cycle in which the timer-overflow input is high.
- R5: Source 011 counts high-to-low transitions of the external pin after a two-flop synchronizer. Accepted transitions are at least 4 system clocks apart, and a transition that comes sooner is dropped.
- R6: Source 101 adds one count per 8 cycles of the external oscillator clock, after that clock is resynchronized into the system clock domain.
- R7: Source codes 110 and 111 produce no counts, so the counter holds.
- R8: While bit7 is 1 and the idle input is high, the counter holds. While bit7 is 0, the idle input has no effect.
- R9: While the watchdog enable is 1, a write changes nothing except this: when the lock is 0 and written bit6 is 0, the enable clears and every other field is kept.
- R10: Once the lock is 1, it stays 1 until reset. While the lock and the enable are both 1, the enable cannot be cleared.
- R11: The overflow flag sets when the counter steps from 0xFFFF to 0x0000. It stays set until the clear input is pulsed, and a wrap in the same cycle as a clear wins.
- R12: The interrupt request is high exactly when the overflow flag and bit0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External oscillator clock, asynchronous to clk |
| tmr_ovf | input | 1 | Timer-overflow pulse, one count per high cycle |
| cnt_pin | input | 1 | External count pin, asynchronous |
| cpu_idle | input | 1 | Processor idle indication |
| reg_wr | input | 1 | Mode register write strobe |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register read value |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wd_enable | output | 1 | Current watchdog enable |

## Verification
The bench measures exact count deltas over windows whose length is a whole number of source periods. A wrong divider ratio or a swapped source code therefore shows up as a wrong delta. A pin train at twice the allowed rate must yield half as many counts; a design without the rate limiter counts every edge, and one with a limiter that is too wide counts too few. Write-protect tests send a write that tries to change every field while the watchdog is enabled, so a design that applies the whole byte, or that lets a locked enable clear, reads back wrong. The counter runs through one full wrap to check that the flag rises exactly on the 0xFFFF-to-0 step, that the interrupt follows the enable bit, and that only the clear input drops the flag.

// File: rtl/ctr_timebase_pkg.sv
`timescale 1ns/1ps
// Shared types for the counter timebase: source codes and mode register layout.
package ctr_timebase_pkg;

    typedef enum logic [2:0] {
        SRC_DIV12 = 3'b000,
        SRC_DIV4  = 3'b001,
        SRC_TMR   = 3'b010,
        SRC_PIN   = 3'b011,
        SRC_SYS   = 3'b100,
        SRC_EXT8  = 3'b101,
        SRC_RSV6  = 3'b110,
        SRC_RSV7  = 3'b111
    } src_sel_e;

    // Field order matches the register bit order, MSB first.
    typedef struct packed {
        logic     idle_hold;   // bit7
        logic     wd_en;       // bit6
        logic     wd_lock;     // bit5
        logic     spare;       // bit4, always 0
        src_sel_e sel;         // bits3..1
        logic     ovf_ie;      // bit0
    } mode_t;

    localparam logic [7:0] MODE_RST_BYTE = 8'h40;

endpackage

// File: rtl/ctb_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for one asynchronous bit.
// Assumes: d is a level that stays stable for several clk cycles; stages are reset to RST_VAL.
module ctb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ctb_mode_reg.sv
`timescale 1ns/1ps
// Mode register with watchdog write protection and a sticky lock.
// Assumes: one write per strobe cycle; reads are combinational.
module ctb_mode_reg
    import ctr_timebase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output mode_t      mode
);
    localparam int EN_BIT   = 6;
    localparam int LOCK_BIT = 5;

    mode_t mode_q, mode_nxt;

    // Next-state: full write when unprotected, enable-clear only when protected and unlocked.
    always_comb begin
        mode_nxt = mode_q;
        if (wr_en) begin
            if (!mode_q.wd_en) begin
                mode_nxt         = mode_t'(wdata);
                mode_nxt.spare   = 1'b0;
                mode_nxt.wd_lock = mode_q.wd_lock | wdata[LOCK_BIT];
            end else if (!mode_q.wd_lock && !wdata[EN_BIT]) begin
                mode_nxt.wd_en = 1'b0;
            end
        end
    end

    // State register with reset to the documented default.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_t'(MODE_RST_BYTE);
        else        mode_q <= mode_nxt;
    end

    assign mode = mode_q;
endmodule

// File: rtl/ctb_tick_sel.sv
`timescale 1ns/1ps
// Source selection: prescalers, pin edge detector with rate limit, external divider and resync.
// Assumes: EXT_DIV is a power of two; ext_clk is slower than clk/2 after division.
module ctb_tick_sel
    import ctr_timebase_pkg::*;
#(
    parameter int DIV_A    = 12,
    parameter int DIV_B    = 4,
    parameter int EXT_DIV  = 8,
    parameter int PIN_GAP  = 4,
    parameter int SYNC_STG = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ext_clk,
    input  logic     tmr_ovf,
    input  logic     cnt_pin,
    input  src_sel_e sel,
    output logic     tick
);
    localparam int AW   = $clog2(DIV_A);
    localparam int BW   = $clog2(DIV_B);
    localparam int EW   = $clog2(EXT_DIV);
    localparam int GW   = $clog2(PIN_GAP);
    localparam logic [AW-1:0] A_TOP = AW'(DIV_A - 1);
    localparam logic [BW-1:0] B_TOP = BW'(DIV_B - 1);
    localparam logic [GW-1:0] G_TOP = GW'(PIN_GAP - 1);

    logic [AW-1:0] div_a;
    logic [BW-1:0] div_b;
    logic          tick_a, tick_b;

    // Free-running system-clock prescalers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_a <= '0;
            div_b <= '0;
        end else begin
            div_a <= (div_a == A_TOP) ? '0 : div_a + 1'b1;
            div_b <= (div_b == B_TOP) ? '0 : div_b + 1'b1;
        end
    end
    assign tick_a = (div_a == A_TOP);
    assign tick_b = (div_b == B_TOP);

    // External pin: synchronize, then detect a high-to-low step.
    logic pin_s, pin_prev, pin_fall, pin_ok;
    logic [GW-1:0] gap_cnt;

    ctb_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(cnt_pin), .q(pin_s)
    );

    // Previous synchronized pin sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b1;
        else        pin_prev <= pin_s;
    end
    assign pin_fall = pin_prev & ~pin_s;
    assign pin_ok   = pin_fall && (gap_cnt == '0);

    // Rate limiter: after an accepted edge, block further edges for PIN_GAP-1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_cnt <= '0;
        else if (pin_ok)         gap_cnt <= G_TOP;
        else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
    end

    // External oscillator divider, running in its own domain.
    logic [EW-1:0] ext_cnt;
    always_ff @(posedge ext_clk) begin
        if (!rst_n) ext_cnt <= '0;
        else        ext_cnt <= ext_cnt + 1'b1;
    end

    // Resync the divider MSB and take its rising edge as one tick.
    logic ext_s, ext_prev, ext_tick;
    ctb_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_cnt[EW-1]), .q(ext_s)
    );

    // Previous resynchronized divider sample.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_s;
    end
    assign ext_tick = ext_s & ~ext_prev;

    // Source multiplexer; reserved codes give no tick.
    always_comb begin
        unique case (sel)
            SRC_DIV12: tick = tick_a;
            SRC_DIV4:  tick = tick_b;
            SRC_TMR:   tick = tmr_ovf;
            SRC_PIN:   tick = pin_ok;
            SRC_SYS:   tick = 1'b1;
            SRC_EXT8:  tick = ext_tick;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctb_counter.sv
`timescale 1ns/1ps
// Free-running up counter with a sticky wrap flag.
// Assumes: adv is a one-cycle-per-count enable; clr is a separate flag-clear strobe.
module ctb_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         flag
);
    logic wrap;
    assign wrap = adv && (&cnt);

    // Counter advances by one per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    // Flag sets on wrap (wins over a clear in the same cycle), cleared by clr.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (wrap) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/ctr_timebase.sv
`timescale 1ns/1ps
// Counter timebase top: mode register, source selection and counter.
// Assumes: clk is the system clock; ext_clk, cnt_pin are asynchronous; tmr_ovf is clk-synchronous.
module ctr_timebase
    import ctr_timebase_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_A    = 12,
    parameter int DIV_B    = 4,
    parameter int EXT_DIV  = 8,
    parameter int PIN_GAP  = 4,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic             tmr_ovf,
    input  logic             cnt_pin,
    input  logic             cpu_idle,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             irq,
    output logic             wd_enable
);
    mode_t mode;
    logic  tick, adv;

    ctb_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata), .mode(mode)
    );

    ctb_tick_sel #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .EXT_DIV(EXT_DIV),
        .PIN_GAP(PIN_GAP), .SYNC_STG(SYNC_STG)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .tmr_ovf(tmr_ovf),
        .cnt_pin(cnt_pin), .sel(mode.sel), .tick(tick)
    );

    // Idle freeze gates the selected tick.
    assign adv = tick && !(mode.idle_hold && cpu_idle);

    ctb_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv), .clr(ovf_clr),
        .cnt(count), .flag(ovf_flag)
    );

    assign reg_rdata = mode;
    assign irq       = ovf_flag & mode.ovf_ie;
    assign wd_enable = mode.wd_en;
endmodule

// File: rtl/ctr_timebase_chk.sv
`timescale 1ns/1ps
// Port-level property checker for ctr_timebase, attached by bind.
module ctr_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_idle,
    input logic [7:0]       reg_rdata,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             irq,
    input logic             wd_enable
);
    p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] == 1'b0);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (count == $past(count) || count == $past(count) + 1'b1));

    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[3:2] == 2'b11) |=> $stable(count));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && cpu_idle) |=> $stable(count));

    p_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6] |=> ($stable(reg_rdata[7]) && $stable(reg_rdata[5:0])));

    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] |=> reg_rdata[5]);

    p_locked_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[5] && wd_enable) |=> wd_enable);

    p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == {CNT_W{1'b1}}) |=> (count != '0 || ovf_flag));

    p_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && reg_rdata[0]));
endmodule

bind ctr_timebase ctr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_idle(cpu_idle), .reg_rdata(reg_rdata),
    .count(count), .ovf_flag(ovf_flag), .irq(irq), .wd_enable(wd_enable)
);

// File: tb/ctr_timebase_test.sv
`timescale 1ns/1ps
// Self-checking bench for ctr_timebase: vector table, then directed tests.
module ctr_timebase_test;
    logic        clk = 1'b0, ext_clk = 1'b0, rst_n = 1'b0;
    logic        tmr_ovf = 1'b0, cnt_pin = 1'b1, cpu_idle = 1'b0;
    logic        reg_wr = 1'b0, ovf_clr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] count;
    logic        ovf_flag, irq, wd_enable;

    int total = 0, bad = 0;
    logic [15:0] c0;

    always #4 clk = ~clk;                 // 125 MHz
    initial begin #1; forever #12 ext_clk = ~ext_clk; end

    ctr_timebase uut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .tmr_ovf(tmr_ovf),
        .cnt_pin(cnt_pin), .cpu_idle(cpu_idle), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_clr(ovf_clr),
        .count(count), .ovf_flag(ovf_flag), .irq(irq), .wd_enable(wd_enable)
    );

    typedef struct packed {
        logic [7:0]  mode;
        logic        idle;
        logic [15:0] cyc;
        logic [15:0] exp;
    } vec_t;

    // mode byte, idle input, window length, expected count delta
    localparam vec_t VEC [9] = '{
        '{8'h08, 1'b0, 16'd50,  16'd50},   // R3 system clock
        '{8'h00, 1'b0, 16'd120, 16'd10},   // R3 divide by 12
        '{8'h02, 1'b0, 16'd40,  16'd10},   // R3 divide by 4
        '{8'h0C, 1'b0, 16'd50,  16'd0},    // R7 code 110
        '{8'h0E, 1'b0, 16'd50,  16'd0},    // R7 code 111
        '{8'h88, 1'b1, 16'd50,  16'd0},    // R8 freeze while idle
        '{8'h08, 1'b1, 16'd50,  16'd50},   // R8 idle ignored when bit7 clear
        '{8'h88, 1'b0, 16'd30,  16'd30},   // R8 bit7 set but not idle
        '{8'h0A, 1'b0, 16'd240, 16'd10}    // R6 external clock / 8
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 190000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mode", {8'h00, reg_rdata}, 16'h0040);
        chk("R1 count", count, 16'h0000);
        chk("R1 flag", {15'd0, ovf_flag}, 16'd0);
        chk("R1 wd_enable", {15'd0, wd_enable}, 16'd1);

        // R9: protected write that also tries to change select only clears enable
        wr(8'h0E);
        chk("R9 enable-clear only", {8'h00, reg_rdata}, 16'h0000);
        // R2 bit4 reads 0
        wr(8'h10);
        chk("R2 spare bit", {8'h00, reg_rdata}, 16'h0000);
        wr(8'h48);
        chk("R2 full write", {8'h00, reg_rdata}, 16'h0048);
        wr(8'h4B);                       // R9 ignored while enabled (bit6 set)
        chk("R9 write ignored", {8'h00, reg_rdata}, 16'h0048);
        wr(8'h03);                       // R9 clears enable, keeps sel
        chk("R9 keep fields", {8'h00, reg_rdata}, 16'h0008);

        // Vector table
        for (int k = 0; k < 9; k++) begin
            wr(VEC[k].mode);
            cpu_idle = VEC[k].idle;
            c0 = count;
            cycles(int'(VEC[k].cyc));
            chk($sformatf("R3/R6/R7/R8 vec %0d", k), count - c0, VEC[k].exp);
            cpu_idle = 1'b0;
        end

        // R4 timer-overflow pulses
        wr(8'h04);
        c0 = count;
        for (int i = 0; i < 7; i++) begin
            tmr_ovf = 1'b1; cycles(1); tmr_ovf = 1'b0; cycles(3);
        end
        cycles(2);
        chk("R4 timer pulses", count - c0, 16'd7);

        // R5 slow pin edges all counted
        wr(8'h06);
        c0 = count;
        for (int i = 0; i < 5; i++) begin
            cnt_pin = 1'b0; cycles(5); cnt_pin = 1'b1; cycles(5);
        end
        cycles(6);
        chk("R5 slow edges", count - c0, 16'd5);
        // R5 edges every 2 cycles: only every other one accepted
        c0 = count;
        for (int i = 0; i < 20; i++) begin
            cnt_pin = 1'b0; cycles(1); cnt_pin = 1'b1; cycles(1);
        end
        cycles(10);
        chk("R5 rate limit", count - c0, 16'd10);

        // R10 lock
        wr(8'h60);
        chk("R10 lock set", {8'h00, reg_rdata}, 16'h0060);
        wr(8'h00);
        chk("R10 clear refused", {8'h00, reg_rdata}, 16'h0060);
        chk("R10 wd_enable held", {15'd0, wd_enable}, 16'd1);
        do_reset();
        chk("R1 after reset", {8'h00, reg_rdata}, 16'h0040);
        chk("R1 count after reset", count, 16'h0000);

        // R11/R12 wrap, flag, irq
        wr(8'h00);
        wr(8'h09);
        for (int g = 0; g < 70000 && count != 16'hFFFF; g++) @(negedge clk);
        chk("R11 at top", count, 16'hFFFF);
        chk("R11 flag before wrap", {15'd0, ovf_flag}, 16'd0);
        cycles(1);
        chk("R11 wrapped", count, 16'h0000);
        chk("R11 flag set", {15'd0, ovf_flag}, 16'd1);
        chk("R12 irq with enable", {15'd0, irq}, 16'd1);
        wr(8'h08);
        chk("R12 irq masked", {15'd0, irq}, 16'd0);
        chk("R11 flag sticky", {15'd0, ovf_flag}, 16'd1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R11 flag cleared", {15'd0, ovf_flag}, 16'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule